// File: doc/BRIEF.md
# Single-Precision Product Normalize-and-Pack Stage

This stage finishes a single-precision floating-point multiply. An upstream significand multiplier forms the 48-bit product of the two 24-bit significands. Each significand is the operand's 23-bit fraction with an implicit leading one placed above it. When that product is ready, the multiplier pulses `prod_vld`. The stage then takes the signs and biased exponents from the two original 32-bit operands and combines them with the product to build the packed 32-bit result.

The stage first checks the top product bit. This test picks which 23-bit window of the product becomes the fraction. The bit just below that window is added as a rounding increment. The result exponent is the sum of the two biased exponents, minus the bias, plus a carry from the window choice and a carry from rounding. The exponent is computed in a signed intermediate two bits wider than the field. This width lets the stage report when the exponent leaves the 8-bit range on either side. Only the low 8 bits are packed.

The stage has two register stages. A result appears two clock cycles after `prod_vld`, together with a one-cycle `res_vld`. Zero, infinity, NaN and subnormal operands are not handled.

Top module: `fpm_pack_stage`

## Requirements
- R1: The result sign `res[31]` is the XOR of `op_a[31]` and `op_b[31]`.
- R2: When `prod[47]` is 1, the fraction `res[22:0]` is `prod[46:24]` plus `prod[23]`, and the exponent receives a normalization carry of 1.
- R3: When `prod[47]` is 0, the fraction is `prod[45:23]` plus `prod[22]`, and the exponent receives no normalization carry.
- R4: If the rounding increment carries out of the 23-bit fraction, the fraction becomes all zeros and the exponent receives one further increment.
- R5: The result exponent is `op_a[30:23] + op_b[30:23] - 127 + normalization carry + rounding carry`. Its low 8 bits are packed into `res[30:23]`. For example, 0x43061000 × 0xC0100000 gives 0xC396D200, 0xC1680000 × 0xBEC00000 gives 0x40AE0000, and 0x40F00000 × 0x41780000 gives 0x42E88000.
- R6: `exp_ovf` is 1 with a result whose true exponent is 256 or more. `exp_unf` is 1 with a result whose true exponent is negative. The two flags are never 1 together, both are 0 whenever `res_vld` is 0, and neither flag changes the packed bits.
- R7: `res_vld` is 1 for exactly one cycle, two clock cycles after each cycle in which `prod_vld` is 1.
- R8: While `prod_vld` is 0, the inputs are ignored: `res` holds its last value and both flags stay 0.
- R9: While `rst` is 1, and in the first cycle after it, `res`, `res_vld`, `exp_ovf` and `exp_unf` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| prod | input | 48 | Product of the two hidden-one-extended significands |
| prod_vld | input | 1 | Product ready; samples `op_a`, `op_b` and `prod` |
| res | output | 32 | Packed single-precision result |
| res_vld | output | 1 | One-cycle pulse marking a new `res` |
| exp_ovf | output | 1 | Result exponent above the 8-bit range |
| exp_unf | output | 1 | Result exponent below zero |

## Verification
The assertions take for granted that `op_a`, `op_b` and `prod` are steady in every cycle where `prod_vld` is high. They do not rely on `prod` being the true significand product. The latency and sign properties hold for any product pattern. The bench nevertheless computes the product from the operands in almost every case, so that the fraction and exponent it predicts are real single-precision results. The bench drives `prod` directly only to force a rounding carry-out and to send junk while `prod_vld` is low. Operand exponents stay above zero and below 255, so no special value is ever formed.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 23;

  function automatic int exp_bias(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/fpm_frac_sel.sv
module fpm_frac_sel #(
  parameter int FRAC_W = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic [PROD_W-1:0] prod,
  output logic [FRAC_W-1:0] kept,
  output logic              rnd_bit,
  output logic              norm_cy
);
  // top bit set: product lies in [2,4), window one place higher
  always_comb begin
    norm_cy = prod[PROD_W-1];
    if (norm_cy) begin
      kept    = prod[PROD_W-2 -: FRAC_W];
      rnd_bit = prod[PROD_W-2-FRAC_W];
    end else begin
      kept    = prod[PROD_W-3 -: FRAC_W];
      rnd_bit = prod[PROD_W-3-FRAC_W];
    end
  end
endmodule

// File: rtl/fpm_round.sv
module fpm_round #(
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W-1:0] kept,
  input  logic              rnd_bit,
  output logic [FRAC_W-1:0] frac,
  output logic              rnd_cy
);
  logic [FRAC_W:0] sum;
  always_comb begin
    sum    = {1'b0, kept} + {{FRAC_W{1'b0}}, rnd_bit};
    frac   = sum[FRAC_W-1:0];
    rnd_cy = sum[FRAC_W];
  end
endmodule

// File: rtl/fpm_exp_add.sv
module fpm_exp_add #(
  parameter int EXP_W = 8,
  localparam int ESUM_W = EXP_W + 2
) (
  input  logic [ESUM_W-1:0] base,
  input  logic              norm_cy,
  input  logic              rnd_cy,
  output logic [EXP_W-1:0]  exp_out,
  output logic              ovf,
  output logic              unf
);
  logic [ESUM_W-1:0] total;
  always_comb begin
    total   = base + {{(ESUM_W-1){1'b0}}, norm_cy} + {{(ESUM_W-1){1'b0}}, rnd_cy};
    exp_out = total[EXP_W-1:0];
    unf     = total[ESUM_W-1];
    ovf     = ~total[ESUM_W-1] & total[EXP_W];
  end
endmodule

// File: rtl/fpm_pack_stage.sv
module fpm_pack_stage #(
  parameter int EXP_W  = fpm_pkg::DEF_EXP_W,
  parameter int FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int PROD_W = 2 * (FRAC_W + 1),
  localparam int ESUM_W = EXP_W + 2,
  localparam int BIAS   = fpm_pkg::exp_bias(EXP_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [PROD_W-1:0] prod,
  input  logic              prod_vld,
  output logic [WORD_W-1:0] res,
  output logic              res_vld,
  output logic              exp_ovf,
  output logic              exp_unf
);
  // stage 1: window selection and exponent base
  logic [FRAC_W-1:0] sel_kept;
  logic              sel_rnd, sel_norm;
  logic [ESUM_W-1:0] base_c;

  fpm_frac_sel #(.FRAC_W(FRAC_W)) u_sel (
    .prod    (prod),
    .kept    (sel_kept),
    .rnd_bit (sel_rnd),
    .norm_cy (sel_norm)
  );

  always_comb begin
    base_c = {2'b00, op_a[WORD_W-2 -: EXP_W]} + {2'b00, op_b[WORD_W-2 -: EXP_W]}
           - ESUM_W'(BIAS);
  end

  logic              s1_vld, s1_sign, s1_rnd, s1_norm;
  logic [FRAC_W-1:0] s1_kept;
  logic [ESUM_W-1:0] s1_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_sign <= 1'b0;
      s1_rnd  <= 1'b0;
      s1_norm <= 1'b0;
      s1_kept <= '0;
      s1_base <= '0;
    end else begin
      s1_vld <= prod_vld;
      if (prod_vld) begin
        s1_sign <= op_a[WORD_W-1] ^ op_b[WORD_W-1];
        s1_rnd  <= sel_rnd;
        s1_norm <= sel_norm;
        s1_kept <= sel_kept;
        s1_base <= base_c;
      end
    end
  end

  // stage 2: round, finish exponent, pack
  logic [FRAC_W-1:0] frac_c;
  logic              rnd_cy;
  logic [EXP_W-1:0]  exp_c;
  logic              ovf_c, unf_c;

  fpm_round #(.FRAC_W(FRAC_W)) u_rnd (
    .kept    (s1_kept),
    .rnd_bit (s1_rnd),
    .frac    (frac_c),
    .rnd_cy  (rnd_cy)
  );

  fpm_exp_add #(.EXP_W(EXP_W)) u_exp (
    .base    (s1_base),
    .norm_cy (s1_norm),
    .rnd_cy  (rnd_cy),
    .exp_out (exp_c),
    .ovf     (ovf_c),
    .unf     (unf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      res_vld <= 1'b0;
      exp_ovf <= 1'b0;
      exp_unf <= 1'b0;
    end else begin
      res_vld <= s1_vld;
      exp_ovf <= s1_vld & ovf_c;
      exp_unf <= s1_vld & unf_c;
      if (s1_vld) res <= {s1_sign, exp_c, frac_c};
    end
  end
endmodule

// File: rtl/fpm_pack_stage_chk.sv
module fpm_pack_stage_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic              prod_vld,
  input logic [WORD_W-1:0] res,
  input logic              res_vld,
  input logic              exp_ovf,
  input logic              exp_unf
);
  logic v1, v2, sg1, sg2;
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; sg1 <= 1'b0; sg2 <= 1'b0;
    end else begin
      v1 <= prod_vld;
      v2 <= v1;
      if (prod_vld) sg1 <= op_a[WORD_W-1] ^ op_b[WORD_W-1];
      if (v1) sg2 <= sg1;
    end
  end

  // R7
  res_latency_chk: assert property (@(posedge clk) disable iff (rst) res_vld == v2);
  // R1
  sign_xor_chk: assert property (@(posedge clk) disable iff (rst) res_vld |-> res[WORD_W-1] == sg2);
  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst) !(exp_ovf && exp_unf));
  // R6
  flag_qual_chk: assert property (@(posedge clk) disable iff (rst) !res_vld |-> !exp_ovf && !exp_unf);
  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (rst) !res_vld |-> $stable(res));
endmodule

bind fpm_pack_stage fpm_pack_stage_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod_vld(prod_vld),
  .res(res), .res_vld(res_vld), .exp_ovf(exp_ovf), .exp_unf(exp_unf)
);

// File: tb/fpm_pack_stage_tb.sv
`timescale 1ns/1ps
module fpm_pack_stage_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0;
  logic [47:0] prod = '0;
  logic        prod_vld = 1'b0;
  logic [31:0] res;
  logic        res_vld, exp_ovf, exp_unf;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  fpm_pack_stage u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod(prod),
    .prod_vld(prod_vld), .res(res), .res_vld(res_vld),
    .exp_ovf(exp_ovf), .exp_unf(exp_unf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  function automatic logic [47:0] sig_prod(input logic [31:0] a, input logic [31:0] b);
    logic [47:0] ma, mb;
    ma = {24'd0, 1'b1, a[22:0]};
    mb = {24'd0, 1'b1, b[22:0]};
    return ma * mb;
  endfunction

  // expected values from the requirements
  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [47:0] p,
                     input string req);
    logic [23:0] sum;
    int          e;
    logic        hi;
    logic [31:0] exp_res;
    hi  = p[47];
    sum = hi ? ({1'b0, p[46:24]} + 24'(p[23]))    // R2
             : ({1'b0, p[45:23]} + 24'(p[22]));   // R3
    e   = int'(a[30:23]) + int'(b[30:23]) - 127 + int'(hi) + int'(sum[23]); // R4 R5
    exp_res = {a[31] ^ b[31], 8'(e), sum[22:0]};  // R1
    @(negedge clk);
    op_a = a; op_b = b; prod = p; prod_vld = 1'b1;
    @(negedge clk);
    prod_vld = 1'b0;
    check({req, " R7 early"}, {31'd0, res_vld}, 32'd0);
    @(negedge clk);
    check({req, " R7 valid"}, {31'd0, res_vld}, 32'd1);
    check(req, res, exp_res);
    check({req, " R6 ovf"}, {31'd0, exp_ovf}, {31'd0, e >= 256});
    check({req, " R6 unf"}, {31'd0, exp_unf}, {31'd0, e < 0});
  endtask

  function automatic logic [22:0] frac_pat(input int i);
    if (i == 0) return 23'h0;
    if (i == 1) return 23'h7FFFFF;
    return 23'(i * 32'h0123457);
  endfunction

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 during reset
    check("R9 res", res, 32'd0);
    check("R9 flags", {29'd0, res_vld, exp_ovf, exp_unf}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 after", {res[31:0] | {29'd0, res_vld, exp_ovf, exp_unf}}, 32'd0);

    // R5 reference vectors
    run(32'h43061000, 32'hC0100000, sig_prod(32'h43061000, 32'hC0100000), "R5 ref1");
    check("R5 ref1 value", res, 32'hC396D200);
    run(32'hC1680000, 32'hBEC00000, sig_prod(32'hC1680000, 32'hBEC00000), "R5 ref2");
    check("R5 ref2 value", res, 32'h40AE0000);
    run(32'h40F00000, 32'h41780000, sig_prod(32'h40F00000, 32'h41780000), "R5 ref3");
    check("R5 ref3 value", res, 32'h42E88000);

    // R4 rounding carry-out, both windows
    run(32'h3F800000, 32'h3F800000, 48'h7FFFFFC00000, "R4 low window");
    check("R4 low value", res, 32'h40000000);
    run(32'h3F800000, 32'hBF800000, 48'hFFFFFF800000, "R4 high window");
    check("R4 high value", res, 32'hC0800000);

    // R6 range exits, packed bits still the low 8 bits
    run(32'h78000000, 32'h78000000, sig_prod(32'h78000000, 32'h78000000), "R6 overflow");
    run(32'h10400000, 32'h90400000, sig_prod(32'h10400000, 32'h90400000), "R6 underflow");
    run(32'h7F000000, 32'h40000000, sig_prod(32'h7F000000, 32'h40000000), "R6 edge 255");

    // R1 R2 R3 sweep over signs, exponents and fraction patterns
    for (int ea = 0; ea < 3; ea++)
      for (int fa = 0; fa < 6; fa++)
        for (int fb = 0; fb < 6; fb++) begin
          logic [31:0] a, b;
          a = {1'(fa), 8'(100 + 27 * ea), frac_pat(fa)};
          b = {1'(fb >> 1), 8'(150 - 23 * ea), frac_pat(fb + 3)};
          run(a, b, sig_prod(a, b), "R1 R2 R3 sweep");
        end

    // R8 inputs ignored without prod_vld
    begin
      logic [31:0] held;
      held = res;
      @(negedge clk);
      op_a = 32'hFFFFFFFF; op_b = 32'h7F7FFFFF; prod = 48'hFFFFFFFFFFFF;
      repeat (4) begin
        @(negedge clk);
        check("R8 hold", res, held);
        check("R8 flags", {29'd0, res_vld, exp_ovf, exp_unf}, 32'd0);
      end
    end
    finish_run();
  end
endmodule